// File: doc/BRIEF.md
# SPI Byte-Framed Configuration Register Writer

This block is an SPI slave that fills the configuration registers of an ultrasound-style acquisition sequencer. Each chip-select frame carries one byte. A register write takes three frames in a row: a marker byte, then a register address, then the data byte. The block brings the three SPI pins into the system clock domain and assembles each byte. A small state machine turns the frame sequence into one internal write, and a register file applies that write.

The register file holds several values as plain output pins: pulse and gap lengths, delay, acquisition length and cycle period, a single or continuous mode bit, a gain DAC level, an ADC clock divider, a continuous-mode cycle count, and a 41-entry time-gain table. Two addresses hold no value. Writing a 1 to either of them gives a one-cycle strobe: one is a software trigger and the other a memory-pointer reset.

The incoming byte stream cannot be back-pressured, because the SPI master cannot be stalled. Every accepted byte is therefore consumed in the cycle it appears, and the outputs are plain levels with no handshake.

Top module: `spi_cfg_writer`

## Requirements
- R1: After reset the outputs take these values: pon_len_o 0x14, gap_len_o 0x0A, poff_len_o 0x00C8, acq_delay_o 0x02BC, acq_len_o 0x32C8, period_o 0x0186A0, dac_level_o 0x11, adc_div_o 0x03, cycle_cnt_o 0x0A, cont_mode_o 0, all gain entries 0x00, and both strobes 0.
- R2: SPI mode 0 is used. MOSI is sampled on each rising SCK edge while spi_csn_i is low, most significant bit first. A frame yields a byte only if exactly 8 rising edges occurred before spi_csn_i returned high. A frame with fewer or more edges is dropped and does not advance the write sequence.
- R3: The frame sequence 0xAA, address, data writes the data to the register at that address.
- R4: When the sequence is idle, a frame whose byte is not 0xAA is discarded and the sequence stays idle.
- R5: Multi-byte values put the most significant byte at the lowest address: poff_len_o is {0xE1,0xE2}, acq_delay_o is {0xE3,0xE4}, acq_len_o is {0xE5,0xE6}, and period_o is {0xE7,0xE8,0xE9}. Single-byte registers are pon_len_o at 0xE0, gap_len_o at 0xD0, dac_level_o at 0xEC, adc_div_o at 0xED and cycle_cnt_o at 0xEE.
- R6: A write to 0xEA with data bit 0 set raises sw_trig_o for exactly one clock. Bit 0 clear gives no strobe, and no register changes either way.
- R7: A write to 0xEF with data bit 0 set raises ptr_reset_o for exactly one clock. Bit 0 clear gives no strobe, and no register changes either way.
- R8: A write to 0xEB sets cont_mode_o to data bit 0, where 1 means continuous and 0 means single. The other data bits are ignored.
- R9: A write to address 0x10+i, for i from 0 to 40, stores the data in gain entry i, which is gain_curve_o[8*i+7:8*i].
- R10: A write to any address not named in R5 to R9 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | SPI clock from the master |
| spi_mosi_i | input | 1 | SPI data from the master |
| spi_csn_i | input | 1 | SPI chip select, active low |
| pon_len_o | output | 8 | Positive pulse length |
| gap_len_o | output | 8 | Gap between positive and negative pulses |
| poff_len_o | output | 16 | Negative pulse length |
| acq_delay_o | output | 16 | Delay before acquisition |
| acq_len_o | output | 16 | Acquisition length |
| period_o | output | 24 | Cycle period |
| cont_mode_o | output | 1 | 1 = continuous, 0 = single |
| dac_level_o | output | 8 | Gain DAC level |
| adc_div_o | output | 8 | ADC clock divider |
| cycle_cnt_o | output | 8 | Cycle count for continuous mode |
| sw_trig_o | output | 1 | One-clock software trigger strobe |
| ptr_reset_o | output | 1 | One-clock memory-pointer reset strobe |
| gain_curve_o | output | 328 | 41 gain entries, entry i at bits 8*i+7:8*i |

## Verification
The assertions check several rules on every cycle:
- Assembled bytes never arrive on two consecutive cycles.
- Every internal write is preceded by an accepted byte.
- Both strobes last exactly one cycle and each follows a write.
- The mode bit and the DAC level stay stable in every cycle that does not follow a write.

Some behaviour can only be shown by the bench scenarios, because it depends on values and sequences: the byte values and MSB-first order, the byte order of the multi-byte registers, dropped short and long frames, discarded non-marker bytes, unmapped addresses, and the mapping of the gain table.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] MARKER = 8'hAA;

  localparam logic [7:0] ADR_GAP      = 8'hD0;
  localparam logic [7:0] ADR_PON      = 8'hE0;
  localparam logic [7:0] ADR_POFF_HI  = 8'hE1;
  localparam logic [7:0] ADR_POFF_LO  = 8'hE2;
  localparam logic [7:0] ADR_DLY_HI   = 8'hE3;
  localparam logic [7:0] ADR_DLY_LO   = 8'hE4;
  localparam logic [7:0] ADR_ACQ_HI   = 8'hE5;
  localparam logic [7:0] ADR_ACQ_LO   = 8'hE6;
  localparam logic [7:0] ADR_PER_HI   = 8'hE7;
  localparam logic [7:0] ADR_PER_MID  = 8'hE8;
  localparam logic [7:0] ADR_PER_LO   = 8'hE9;
  localparam logic [7:0] ADR_TRIG     = 8'hEA;
  localparam logic [7:0] ADR_MODE     = 8'hEB;
  localparam logic [7:0] ADR_DAC      = 8'hEC;
  localparam logic [7:0] ADR_DIV      = 8'hED;
  localparam logic [7:0] ADR_CYC      = 8'hEE;
  localparam logic [7:0] ADR_PRST     = 8'hEF;

  localparam logic [7:0]  DEF_PON  = 8'h14;
  localparam logic [7:0]  DEF_GAP  = 8'h0A;
  localparam logic [15:0] DEF_POFF = 16'h00C8;
  localparam logic [15:0] DEF_DLY  = 16'h02BC;
  localparam logic [15:0] DEF_ACQ  = 16'h32C8;
  localparam logic [23:0] DEF_PER  = 24'h0186A0;
  localparam logic [7:0]  DEF_DAC  = 8'h11;
  localparam logic [7:0]  DEF_DIV  = 8'h03;
  localparam logic [7:0]  DEF_CYC  = 8'h0A;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spiw_sync.sv
module spiw_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[s] <= RST_VAL;
      end else if (s == 0) begin
        stg[s] <= d_i;
      end else begin
        stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spiw_deframer.sv
module spiw_deframer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BYTE_W + 1);

  logic              sck_q;
  logic              csn_q;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              sck_rise;
  logic              frame_end;

  assign sck_rise  = sck_s & ~sck_q;
  assign frame_end = csn_s & ~csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      csn_q      <= 1'b1;
      shreg      <= '0;
      cnt        <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      csn_q      <= csn_s;
      byte_vld_o <= frame_end && (cnt == CNT_FULL);
      if (frame_end) begin
        byte_o <= shreg;
      end
      if (csn_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[BYTE_W-2:0], mosi_s};
        if (cnt != CNT_OVER) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiw_seq.sv
module spiw_seq
  import spiw_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] MARK = BYTE_W'(MARKER)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  seq_state_e        state;
  logic [BYTE_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      addr_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (byte_vld_i) begin
        unique case (state)
          SEQ_IDLE: begin
            if (byte_i == MARK) begin
              state <= SEQ_ADDR;
            end
          end
          SEQ_ADDR: begin
            addr_q <= byte_i;
            state  <= SEQ_DATA;
          end
          SEQ_DATA: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= byte_i;
            state     <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spiw_regfile.sv
module spiw_regfile
  import spiw_pkg::*;
#(
  parameter int unsigned GAIN_N = 41,
  parameter int unsigned GAIN_BASE = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [7:0]            pon_len_o,
  output logic [7:0]            gap_len_o,
  output logic [15:0]           poff_len_o,
  output logic [15:0]           acq_delay_o,
  output logic [15:0]           acq_len_o,
  output logic [23:0]           period_o,
  output logic                  cont_mode_o,
  output logic [7:0]            dac_level_o,
  output logic [7:0]            adc_div_o,
  output logic [7:0]            cycle_cnt_o,
  output logic                  sw_trig_o,
  output logic                  ptr_reset_o,
  output logic [GAIN_N*8-1:0]   gain_curve_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pon_len_o   <= DEF_PON;
      gap_len_o   <= DEF_GAP;
      poff_len_o  <= DEF_POFF;
      acq_delay_o <= DEF_DLY;
      acq_len_o   <= DEF_ACQ;
      period_o    <= DEF_PER;
      cont_mode_o <= 1'b0;
      dac_level_o <= DEF_DAC;
      adc_div_o   <= DEF_DIV;
      cycle_cnt_o <= DEF_CYC;
      sw_trig_o   <= 1'b0;
      ptr_reset_o <= 1'b0;
    end else begin
      sw_trig_o   <= wr_en_i && (wr_addr_i == ADR_TRIG) && wr_data_i[0];
      ptr_reset_o <= wr_en_i && (wr_addr_i == ADR_PRST) && wr_data_i[0];
      if (wr_en_i) begin
        case (wr_addr_i)
          ADR_PON:     pon_len_o         <= wr_data_i;
          ADR_GAP:     gap_len_o         <= wr_data_i;
          ADR_POFF_HI: poff_len_o[15:8]  <= wr_data_i;
          ADR_POFF_LO: poff_len_o[7:0]   <= wr_data_i;
          ADR_DLY_HI:  acq_delay_o[15:8] <= wr_data_i;
          ADR_DLY_LO:  acq_delay_o[7:0]  <= wr_data_i;
          ADR_ACQ_HI:  acq_len_o[15:8]   <= wr_data_i;
          ADR_ACQ_LO:  acq_len_o[7:0]    <= wr_data_i;
          ADR_PER_HI:  period_o[23:16]   <= wr_data_i;
          ADR_PER_MID: period_o[15:8]    <= wr_data_i;
          ADR_PER_LO:  period_o[7:0]     <= wr_data_i;
          ADR_MODE:    cont_mode_o       <= wr_data_i[0];
          ADR_DAC:     dac_level_o       <= wr_data_i;
          ADR_DIV:     adc_div_o         <= wr_data_i;
          ADR_CYC:     cycle_cnt_o       <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar gi = 0; gi < GAIN_N; gi++) begin : g_gain
    localparam int unsigned ENTRY_ADR = GAIN_BASE + gi;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_curve_o[8*gi +: 8] <= 8'h00;
      end else if (wr_en_i && (wr_addr_i == ENTRY_ADR[7:0])) begin
        gain_curve_o[8*gi +: 8] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/spi_cfg_writer.sv
module spi_cfg_writer
  import spiw_pkg::*;
#(
  parameter int unsigned GAIN_N = 41,
  parameter int unsigned GAIN_BASE = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck_i,
  input  logic                spi_mosi_i,
  input  logic                spi_csn_i,
  output logic [7:0]          pon_len_o,
  output logic [7:0]          gap_len_o,
  output logic [15:0]         poff_len_o,
  output logic [15:0]         acq_delay_o,
  output logic [15:0]         acq_len_o,
  output logic [23:0]         period_o,
  output logic                cont_mode_o,
  output logic [7:0]          dac_level_o,
  output logic [7:0]          adc_div_o,
  output logic [7:0]          cycle_cnt_o,
  output logic                sw_trig_o,
  output logic                ptr_reset_o,
  output logic [GAIN_N*8-1:0] gain_curve_o
);
  logic [2:0]        pins_s;
  logic [BYTE_W-1:0] byte_dat;
  logic              byte_vld;
  logic              wr_en;
  logic [7:0]        wr_addr;
  logic [7:0]        wr_data;

  spiw_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_csn_i, spi_mosi_i, spi_sck_i}),
    .q_o   (pins_s)
  );

  spiw_deframer #(.BYTE_W(BYTE_W)) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[0]),
    .mosi_s     (pins_s[1]),
    .csn_s      (pins_s[2]),
    .byte_o     (byte_dat),
    .byte_vld_o (byte_vld)
  );

  spiw_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (byte_dat),
    .byte_vld_i (byte_vld),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  spiw_regfile #(
    .GAIN_N    (GAIN_N),
    .GAIN_BASE (GAIN_BASE)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .pon_len_o    (pon_len_o),
    .gap_len_o    (gap_len_o),
    .poff_len_o   (poff_len_o),
    .acq_delay_o  (acq_delay_o),
    .acq_len_o    (acq_len_o),
    .period_o     (period_o),
    .cont_mode_o  (cont_mode_o),
    .dac_level_o  (dac_level_o),
    .adc_div_o    (adc_div_o),
    .cycle_cnt_o  (cycle_cnt_o),
    .sw_trig_o    (sw_trig_o),
    .ptr_reset_o  (ptr_reset_o),
    .gain_curve_o (gain_curve_o)
  );
endmodule

// File: rtl/spiw_checker.sv
module spiw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       wr_en,
  input logic       sw_trig_o,
  input logic       ptr_reset_o,
  input logic       cont_mode_o,
  input logic [7:0] dac_level_o
);
  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  assert_write_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_vld));

  assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(dac_level_o));

  assert_trig_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig_o |=> !sw_trig_o);

  assert_trig_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig_o |-> $past(wr_en));

  assert_prst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reset_o |=> !ptr_reset_o);

  assert_prst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reset_o |-> $past(wr_en));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cont_mode_o));
endmodule

bind spi_cfg_writer spiw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_vld    (byte_vld),
  .wr_en       (wr_en),
  .sw_trig_o   (sw_trig_o),
  .ptr_reset_o (ptr_reset_o),
  .cont_mode_o (cont_mode_o),
  .dac_level_o (dac_level_o)
);

// File: tb/spi_cfg_writer_bench.sv
`timescale 1ns/1ps
module spi_cfg_writer_bench;
  localparam int GN = 41;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic csn = 1'b1;

  logic [7:0]      pon, gap, dac, dv, cyc;
  logic [15:0]     poff, dly, acq;
  logic [23:0]     per;
  logic            cont, trig, prst;
  logic [GN*8-1:0] gain;

  always #4 clk = ~clk;

  spi_cfg_writer u_spi_cfg_writer (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_csn_i(csn),
    .pon_len_o(pon), .gap_len_o(gap), .poff_len_o(poff), .acq_delay_o(dly),
    .acq_len_o(acq), .period_o(per), .cont_mode_o(cont), .dac_level_o(dac),
    .adc_div_o(dv), .cycle_cnt_o(cyc), .sw_trig_o(trig), .ptr_reset_o(prst),
    .gain_curve_o(gain)
  );

  int checks = 0;
  int fails = 0;
  int trig_seen = 0;
  int prst_seen = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (trig) trig_seen++;
    if (prst) prst_seen++;
  end

  // expected model
  logic [7:0]  e_pon, e_gap, e_dac, e_div, e_cyc;
  logic [15:0] e_poff, e_dly, e_acq;
  logic [23:0] e_per;
  logic        e_cont;
  logic [7:0]  e_gain [GN];
  int          e_trig, e_prst;

  task automatic model_reset();
    e_pon = 8'h14; e_gap = 8'h0A; e_poff = 16'h00C8; e_dly = 16'h02BC;
    e_acq = 16'h32C8; e_per = 24'h0186A0; e_cont = 1'b0; e_dac = 8'h11;
    e_div = 8'h03; e_cyc = 8'h0A; e_trig = 0; e_prst = 0;
    for (int i = 0; i < GN; i++) e_gain[i] = 8'h00;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'hE0: e_pon = d;
      8'hD0: e_gap = d;
      8'hE1: e_poff[15:8] = d;
      8'hE2: e_poff[7:0] = d;
      8'hE3: e_dly[15:8] = d;
      8'hE4: e_dly[7:0] = d;
      8'hE5: e_acq[15:8] = d;
      8'hE6: e_acq[7:0] = d;
      8'hE7: e_per[23:16] = d;
      8'hE8: e_per[15:8] = d;
      8'hE9: e_per[7:0] = d;
      8'hEA: e_trig += int'(d[0]);
      8'hEB: e_cont = d[0];
      8'hEC: e_dac = d;
      8'hED: e_div = d;
      8'hEE: e_cyc = d;
      8'hEF: e_prst += int'(d[0]);
      default: if (a >= 8'h10 && a <= 8'h38) e_gain[a - 8'h10] = d;
    endcase
  endtask

  function automatic logic [112:0] exp_scalar();
    return {e_pon, e_gap, e_poff, e_dly, e_acq, e_per, e_cont, e_dac, e_div, e_cyc};
  endfunction

  function automatic logic [GN*8-1:0] exp_gain();
    logic [GN*8-1:0] v;
    for (int i = 0; i < GN; i++) v[8*i +: 8] = e_gain[i];
    return v;
  endfunction

  task automatic check_all(input string req);
    logic [112:0] act;
    act = {pon, gap, poff, dly, acq, per, cont, dac, dv, cyc};
    checks++;
    if (act !== exp_scalar() || gain !== exp_gain() ||
        trig_seen != e_trig || prst_seen != e_prst) begin
      fails++;
      $display("FAIL %s: regs act=%h exp=%h gain act=%h exp=%h trig act=%0d exp=%0d prst act=%0d exp=%0d",
               req, act, exp_scalar(), gain, exp_gain(), trig_seen, e_trig, prst_seen, e_prst);
    end
  endtask

  task automatic spi_frame(input logic [7:0] b, input int nbits);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? b[3'(7 - i)] : 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_write(input logic [7:0] a, input logic [7:0] d);
    spi_frame(8'hAA, 8);
    spi_frame(a, 8);
    spi_frame(d, 8);
    model_write(a, d);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset defaults");

    spi_write(8'hE0, 8'h5A);
    check_all("R3 single write");

    spi_write(8'hE1, 8'h12); spi_write(8'hE2, 8'h34);
    spi_write(8'hE5, 8'hC1); spi_write(8'hE6, 8'h07);
    check_all("R5 16-bit byte order");
    spi_write(8'hE7, 8'h0A); spi_write(8'hE8, 8'hBC); spi_write(8'hE9, 8'h3D);
    spi_write(8'hD0, 8'h81);
    check_all("R5 24-bit byte order");

    spi_write(8'hEA, 8'h01);
    check_all("R6 trigger strobe");
    spi_write(8'hEA, 8'hFE);
    spi_write(8'hEA, 8'h00);
    check_all("R6 trigger bit0 clear no strobe");

    spi_write(8'hEF, 8'h81);
    spi_write(8'hEF, 8'h80);
    check_all("R7 pointer reset strobe");

    spi_write(8'hEB, 8'h03);
    check_all("R8 continuous mode");
    spi_write(8'hEB, 8'h02);
    check_all("R8 single mode upper bits ignored");

    spi_write(8'h10, 8'hA1); spi_write(8'h38, 8'hB2); spi_write(8'h24, 8'h77);
    check_all("R9 gain table entries");

    spi_write(8'h0F, 8'h99); spi_write(8'h39, 8'h98); spi_write(8'hD1, 8'h97);
    spi_write(8'hF0, 8'h96); spi_write(8'hAA, 8'h95); spi_write(8'hDF, 8'h94);
    check_all("R10 unmapped addresses ignored");

    spi_frame(8'h55, 8);
    spi_write(8'hEC, 8'h9C);
    check_all("R4 junk byte then write");
    spi_frame(8'h12, 8); spi_frame(8'hE0, 8); spi_frame(8'h44, 8);
    check_all("R4 sequence without marker discarded");

    spi_frame(8'hAA, 8); spi_frame(8'h3C, 5); spi_frame(8'hED, 8); spi_frame(8'h07, 8);
    model_write(8'hED, 8'h07);
    check_all("R2 short frame dropped mid sequence");
    spi_frame(8'hAA, 10); spi_frame(8'hED, 8); spi_frame(8'h09, 8);
    check_all("R2 long frame dropped");

    for (int it = 0; it < 350; it++) begin
      int unsigned sel;
      logic [7:0] a, d, junk;
      sel = $urandom % 8;
      d = 8'($urandom);
      case ($urandom % 4)
        0: a = 8'hE0 + 8'($urandom % 16);
        1: a = 8'h10 + 8'($urandom % 41);
        2: a = 8'hD0;
        default: a = 8'($urandom);
      endcase
      if (sel == 0) begin
        junk = 8'($urandom);
        if (junk == 8'hAA) junk = 8'h00;
        spi_frame(junk, 8);
        check_all("R4 random junk byte");
      end else if (sel == 1) begin
        spi_frame(8'hAA, 8);
        spi_frame(8'($urandom), 1 + int'($urandom % 7));
        spi_frame(a, 8);
        spi_frame(d, 8);
        model_write(a, d);
        check_all("R2 random short frame");
      end else begin
        spi_write(a, d);
        check_all("R3 R10 random write");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule